// File: doc/BRIEF.md
# Reset and Interrupt Vector Fetcher

This block stands between a small processor core and a word-addressed memory port. It owns the start-up sequence. Once reset is released it reads two words from the bottom of a table of addresses. The first word becomes the stack pointer and the second becomes the program counter. Only after that does it let the core run. Every entry in the table is an address that goes straight into the program counter. No entry is ever executed as an instruction, so neither start-up nor interrupt entry needs an assembly wrapper.

Interrupts are vectored: the table slot alone picks the handler. When a request is taken, the block first pushes a fixed eight-word frame of core state below the current stack pointer. It then lowers the stack pointer by the frame size and reads the handler address from the interrupt's slot. Finally it puts the core into handler mode and lets it run again. The core has only two modes, thread and handler. Nesting, priority between sources and the return from an exception are handled elsewhere.

Top module: `vec_fetch_unit`

## Requirements
- R1: The first memory access after reset is released is a read of byte address 0. Its data, with bits 1:0 forced to zero, is loaded into `sp_out`.
- R2: The second access is a read of byte address 4. Its data, with bit 0 cleared, is loaded into `pc_out`. `core_run` then goes high in thread mode (`mode_handler` = 0).
- R3: `core_run` is low from reset until the start-up program counter load completes, and low for the whole of an interrupt entry. `mem_valid` and `core_run` are never high together. During reset `sp_out`, `pc_out`, `mode_handler` and `core_run` are all zero.
- R4: A transfer completes only in a cycle where `mem_valid` and `mem_ready` are both high, and the block waits any number of cycles for this. While it waits, `mem_addr`, `mem_write` and `mem_wdata` do not change.
- R5: A request is taken only while `core_run` is high and the mode is thread. Request number k uses table slot 16+k at byte address 4*(16+k). A number with 16+k not below `NUM_SLOTS` is ignored: no bus access follows it and no output changes.
- R6: On entry the block writes eight words at old_sp-4, old_sp-8, … old_sp-32, in that order. `ctx_words` holds word i in bits [32i+31:32i], with i = 0..3 for the argument registers, 4 for R12, 5 for LR, 6 for PC and 7 for status. The writes carry words 7, 6, … 0, taken from the value `ctx_words` had in the cycle the request was taken.
- R7: `sp_out` keeps its old value during the eight writes. It becomes old_sp-32 when the last write completes, which is before the handler address is read.
- R8: The word read from the interrupt's slot, with bit 0 cleared, is loaded into `pc_out`. In the same step `mode_handler` goes high and `core_run` goes high again.
- R9: Once in handler mode, the block stays there until reset and ignores all further requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts or returns the word this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| irq_req | input | 1 | Interrupt request level |
| irq_num | input | IRQ_W | External interrupt number |
| ctx_words | input | 256 | Core state to save, eight 32-bit words |
| core_run | output | 1 | Core may execute |
| mode_handler | output | 1 | 1 = handler mode, 0 = thread mode |
| sp_out | output | 32 | Stack pointer value for the core |
| pc_out | output | 32 | Program counter value to start from |

## Verification
The closest collision is between the start-up program counter load completing and an interrupt request that is already pending. The bench holds a request high through the whole start-up sequence, with random memory waits. The reference model must then see the request ignored in the cycle the reset handler address arrives, and taken in the very next cycle, with no gap where `core_run` could stay high. A second overlap is the last frame write finishing in the same cycle as the stack pointer update. This is judged by comparing `sp_out` and the following vector read address against the model on every clock.

// File: rtl/vfu_pkg.sv
package vfu_pkg;
  localparam int WORD_W      = 32;
  localparam int FRAME_WORDS = 8;
  localparam int EXT_BASE    = 16;

  typedef enum logic [2:0] {
    VS_SP   = 3'd0,
    VS_RST  = 3'd1,
    VS_RUN  = 3'd2,
    VS_PUSH = 3'd3,
    VS_VEC  = 3'd4
  } vfu_state_e;

  // stack pointer must be word aligned
  function automatic logic [31:0] sp_align(logic [31:0] raw);
    return {raw[31:2], 2'b00};
  endfunction

  // handler addresses carry a state flag in bit 0 that is dropped
  function automatic logic [31:0] pc_align(logic [31:0] raw);
    return {raw[31:1], 1'b0};
  endfunction

  function automatic logic [31:0] slot_byte(logic [31:0] slot);
    return slot << 2;
  endfunction

  // k-th frame write, counting from the top of the frame downwards
  function automatic logic [31:0] push_byte(logic [31:0] base, logic [31:0] k);
    return base - ((k + 32'd1) << 2);
  endfunction
endpackage

// File: rtl/vfu_ctrl.sv
module vfu_ctrl
  import vfu_pkg::*;
#(
  parameter int NWORDS = FRAME_WORDS,
  parameter int PIDX_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_done,
  input  logic              irq_ok,
  input  logic              in_handler,
  output vfu_state_e        state,
  output logic [PIDX_W-1:0] push_idx,
  output logic              ev_sp_load,
  output logic              ev_pc_load,
  output logic              ev_irq_take,
  output logic              ev_frame_done,
  output logic              ev_vec_load
);
  localparam logic [PIDX_W-1:0] LAST_IDX = PIDX_W'(NWORDS - 1);

  assign ev_sp_load    = (state == VS_SP)   && bus_done;
  assign ev_pc_load    = (state == VS_RST)  && bus_done;
  assign ev_irq_take   = (state == VS_RUN)  && !in_handler && irq_ok;
  assign ev_frame_done = (state == VS_PUSH) && bus_done && (push_idx == LAST_IDX);
  assign ev_vec_load   = (state == VS_VEC)  && bus_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= VS_SP;
      push_idx <= '0;
    end else begin
      case (state)
        VS_SP:   if (bus_done) state <= VS_RST;
        VS_RST:  if (bus_done) state <= VS_RUN;
        VS_RUN:  if (ev_irq_take) begin
                   state    <= VS_PUSH;
                   push_idx <= '0;
                 end
        VS_PUSH: if (bus_done) begin
                   if (push_idx == LAST_IDX) state <= VS_VEC;
                   else push_idx <= push_idx + 1'b1;
                 end
        VS_VEC:  if (bus_done) state <= VS_RUN;
        default: state <= VS_SP;
      endcase
    end
  end
endmodule

// File: rtl/vfu_regs.sv
module vfu_regs
  import vfu_pkg::*;
#(
  parameter int SLOT_W = 8,
  parameter int IRQ_W  = 8,
  parameter int NWORDS = FRAME_WORDS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ev_sp_load,
  input  logic                     ev_pc_load,
  input  logic                     ev_irq_take,
  input  logic                     ev_frame_done,
  input  logic                     ev_vec_load,
  input  logic [WORD_W-1:0]        rdata,
  input  logic [IRQ_W-1:0]         irq_num,
  input  logic [NWORDS*WORD_W-1:0] ctx_in,
  output logic [WORD_W-1:0]        sp_q,
  output logic [WORD_W-1:0]        pc_q,
  output logic                     handler_q,
  output logic [SLOT_W-1:0]        slot_q,
  output logic [NWORDS*WORD_W-1:0] ctx_q
);
  localparam logic [WORD_W-1:0] FRAME_BYTES = WORD_W'(NWORDS * 4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q      <= '0;
      pc_q      <= '0;
      handler_q <= 1'b0;
      slot_q    <= '0;
      ctx_q     <= '0;
    end else begin
      if (ev_sp_load)    sp_q <= sp_align(rdata);
      if (ev_frame_done) sp_q <= sp_q - FRAME_BYTES;
      if (ev_pc_load || ev_vec_load) pc_q <= pc_align(rdata);
      if (ev_vec_load)   handler_q <= 1'b1;
      if (ev_irq_take) begin
        slot_q <= SLOT_W'(32'(irq_num) + 32'(EXT_BASE));
        ctx_q  <= ctx_in;
      end
    end
  end
endmodule

// File: rtl/vfu_port.sv
module vfu_port
  import vfu_pkg::*;
#(
  parameter int SLOT_W = 8,
  parameter int NWORDS = FRAME_WORDS,
  parameter int PIDX_W = $clog2(NWORDS)
) (
  input  vfu_state_e               state,
  input  logic [PIDX_W-1:0]        push_idx,
  input  logic [WORD_W-1:0]        sp_q,
  input  logic [SLOT_W-1:0]        slot_q,
  input  logic [NWORDS*WORD_W-1:0] ctx_q,
  output logic                     mem_valid,
  output logic                     mem_write,
  output logic [WORD_W-1:0]        mem_addr,
  output logic [WORD_W-1:0]        mem_wdata
);
  always_comb begin
    mem_valid = (state != VS_RUN);
    mem_write = (state == VS_PUSH);
    mem_wdata = '0;
    case (state)
      VS_SP:   mem_addr = 32'h0;
      VS_RST:  mem_addr = 32'h4;
      VS_PUSH: begin
        mem_addr  = push_byte(sp_q, 32'(push_idx));
        mem_wdata = ctx_q[(NWORDS - 1 - int'(push_idx)) * WORD_W +: WORD_W];
      end
      VS_VEC:  mem_addr = slot_byte(32'(slot_q));
      default: mem_addr = 32'h0;
    endcase
  end
endmodule

// File: rtl/vec_fetch_unit.sv
module vec_fetch_unit
  import vfu_pkg::*;
#(
  parameter int NUM_SLOTS = 256,
  parameter int IRQ_W     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic                          mem_valid,
  output logic                          mem_write,
  output logic [31:0]                   mem_addr,
  output logic [31:0]                   mem_wdata,
  input  logic                          mem_ready,
  input  logic [31:0]                   mem_rdata,
  input  logic                          irq_req,
  input  logic [IRQ_W-1:0]              irq_num,
  input  logic [FRAME_WORDS*WORD_W-1:0] ctx_words,
  output logic                          core_run,
  output logic                          mode_handler,
  output logic [31:0]                   sp_out,
  output logic [31:0]                   pc_out
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int PIDX_W = $clog2(FRAME_WORDS);

  vfu_state_e                    state;
  logic [PIDX_W-1:0]             push_idx;
  logic [SLOT_W-1:0]             slot_q;
  logic [FRAME_WORDS*WORD_W-1:0] ctx_q;
  logic bus_done, irq_ok;
  logic ev_sp_load, ev_pc_load, ev_irq_take, ev_frame_done, ev_vec_load;

  assign bus_done = mem_valid && mem_ready;
  assign irq_ok   = irq_req && ((32'(irq_num) + 32'(EXT_BASE)) < 32'(NUM_SLOTS));
  assign core_run = (state == VS_RUN);

  vfu_ctrl #(.NWORDS(FRAME_WORDS), .PIDX_W(PIDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_done(bus_done), .irq_ok(irq_ok),
    .in_handler(mode_handler), .state(state), .push_idx(push_idx),
    .ev_sp_load(ev_sp_load), .ev_pc_load(ev_pc_load), .ev_irq_take(ev_irq_take),
    .ev_frame_done(ev_frame_done), .ev_vec_load(ev_vec_load)
  );

  vfu_regs #(.SLOT_W(SLOT_W), .IRQ_W(IRQ_W), .NWORDS(FRAME_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .ev_sp_load(ev_sp_load), .ev_pc_load(ev_pc_load),
    .ev_irq_take(ev_irq_take), .ev_frame_done(ev_frame_done), .ev_vec_load(ev_vec_load),
    .rdata(mem_rdata), .irq_num(irq_num), .ctx_in(ctx_words),
    .sp_q(sp_out), .pc_q(pc_out), .handler_q(mode_handler), .slot_q(slot_q), .ctx_q(ctx_q)
  );

  vfu_port #(.SLOT_W(SLOT_W), .NWORDS(FRAME_WORDS), .PIDX_W(PIDX_W)) u_port (
    .state(state), .push_idx(push_idx), .sp_q(sp_out), .slot_q(slot_q), .ctx_q(ctx_q),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/vfu_checker.sv
module vfu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_write,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        core_run,
  input logic        mode_handler,
  input logic [31:0] sp_out,
  input logic [31:0] pc_out,
  input logic        ev_sp_load,
  input logic        ev_vec_load,
  input logic        bus_done
);
  assert_first_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sp_load |-> (mem_addr == 32'h0 && !mem_write));

  assert_sp_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |-> (sp_out[1:0] == 2'b00));

  assert_second_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sp_load |=> (mem_valid && !mem_write && mem_addr == 32'h4));

  assert_no_run_on_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !core_run);

  assert_hold_while_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));

  assert_push_descends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_done && mem_write) |=>
      (!mem_valid || !mem_write || mem_addr == $past(mem_addr) - 32'd4));

  assert_pc_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |-> !pc_out[0]);

  assert_vector_enters_handler_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vec_load |=> (mode_handler && core_run));

  assert_handler_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_handler |=> mode_handler);
endmodule

bind vec_fetch_unit vfu_checker u_vfu_checker (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .core_run(core_run), .mode_handler(mode_handler), .sp_out(sp_out), .pc_out(pc_out),
  .ev_sp_load(ev_sp_load), .ev_vec_load(ev_vec_load), .bus_done(bus_done)
);

// File: tb/test_vec_fetch_unit.sv
module test_vec_fetch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SLOTS  = 256;
  localparam int IRQ_W      = 8;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic rst_n = 1'b0;
  logic mem_valid, mem_write, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic irq_req = 1'b0;
  logic [IRQ_W-1:0] irq_num = '0;
  logic [255:0] ctx_words = '0;
  logic core_run, mode_handler;
  logic [31:0] sp_out, pc_out;

  vec_fetch_unit #(.NUM_SLOTS(NUM_SLOTS), .IRQ_W(IRQ_W)) i_vec_fetch_unit (
    .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .irq_req(irq_req), .irq_num(irq_num),
    .ctx_words(ctx_words), .core_run(core_run), .mode_handler(mode_handler),
    .sp_out(sp_out), .pc_out(pc_out)
  );

  // stimulus requested by the test flow, applied at the next falling edge
  logic nx_irq_req = 1'b0;
  logic [IRQ_W-1:0] nx_irq_num = '0;
  logic [255:0] nx_ctx = '0;

  int n_checks = 0, n_errs = 0, cycles = 0;
  int wait_mode = 0;
  logic [31:0] lfsr = 32'hACE1_0001;
  logic [31:0] mem_seed = '0;

  // reference model: pending transfers as queues, 0 sp read, 1 reset read,
  // 2 frame write, 3 last frame write, 4 vector read
  int q_kind[$];
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  logic [31:0] m_sp = '0, m_pc = '0;
  bit m_run = 0, m_handler = 0, prev_stall = 0;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    if (a == 32'h0) return mem_seed | 32'h3;
    if (a == 32'h4) return {16'h0001, mem_seed[15:0]} | 32'h1;
    return {mem_seed[31:16] ^ 16'h0800, a[15:0]} | 32'h1;
  endfunction

  function automatic logic [255:0] make_ctx(logic [31:0] base);
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = base + 32'(i) * 32'h0111_0011;
    return v;
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string req, string what);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  function automatic string kind_req(int k);
    case (k)
      0: return "R1";
      1: return "R2";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic tick();
    bit exp_valid;
    int k;
    logic [31:0] d;
    @(negedge clk);
    cycles++;
    if (cycles > WATCHDOG) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
      finish_run();
    end
    exp_valid = (q_kind.size() > 0);
    if (rst_n) begin
      chk(32'(mem_valid), 32'(exp_valid), "R3", "mem_valid");
      chk(32'(core_run), 32'(m_run), "R3", "core_run");
      chk(sp_out, m_sp, "R7", "sp_out");
      chk(pc_out, m_pc, "R8", "pc_out");
      chk(32'(mode_handler), 32'(m_handler), "R9", "mode_handler");
      if (exp_valid) begin
        chk(mem_addr, q_addr[0], prev_stall ? "R4" : kind_req(q_kind[0]), "mem_addr");
        chk(32'(mem_write), 32'(q_kind[0] == 2 || q_kind[0] == 3), "R6", "mem_write");
        if (q_kind[0] == 2 || q_kind[0] == 3) chk(mem_wdata, q_data[0], "R6", "mem_wdata");
      end
    end else begin
      chk(32'(core_run), 0, "R3", "core_run in reset");
      chk(32'(mode_handler), 0, "R3", "mode in reset");
      chk(sp_out, 0, "R3", "sp in reset");
      chk(pc_out, 0, "R3", "pc in reset");
    end
    // apply inputs for the coming rising edge
    irq_req   = nx_irq_req;
    irq_num   = nx_irq_num;
    ctx_words = nx_ctx;
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    if (!rst_n) mem_ready = 1'b0;
    else if (wait_mode == 0) mem_ready = 1'b1;
    else mem_ready = (lfsr[2:0] > 3'd4);
    mem_rdata = mem_word(mem_addr);
    // step the model with those same inputs
    if (rst_n) begin
      if (exp_valid) begin
        if (mem_ready) begin
          k = q_kind.pop_front();
          void'(q_addr.pop_front());
          d = q_data.pop_front();
          case (k)
            0: m_sp = mem_rdata & ~32'h3;
            1: begin m_pc = mem_rdata & ~32'h1; m_run = 1; end
            3: m_sp = m_sp - 32'd32;
            4: begin m_pc = mem_rdata & ~32'h1; m_handler = 1; m_run = 1; end
            default: ;
          endcase
        end
      end else if (m_run && !m_handler && irq_req && (int'(irq_num) + 16 < NUM_SLOTS)) begin
        m_run = 0;
        for (int j = 0; j < 8; j++) begin
          q_kind.push_back(j == 7 ? 3 : 2);
          q_addr.push_back(m_sp - 32'(4 * (j + 1)));
          q_data.push_back(ctx_words[(7 - j) * 32 +: 32]);
        end
        q_kind.push_back(4);
        q_addr.push_back(32'(4 * (16 + int'(irq_num))));
        q_data.push_back(32'h0);
      end
    end
    prev_stall = exp_valid && !mem_ready && rst_n;
  endtask

  task automatic do_reset(logic [31:0] seed, int wmode);
    rst_n = 1'b0;
    mem_seed = seed;
    wait_mode = wmode;
    q_kind.delete(); q_addr.delete(); q_data.delete();
    m_sp = '0; m_pc = '0; m_run = 0; m_handler = 0; prev_stall = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    q_kind.push_back(0); q_addr.push_back(32'h0); q_data.push_back(32'h0);
    q_kind.push_back(1); q_addr.push_back(32'h4); q_data.push_back(32'h0);
  endtask

  task automatic wait_until_run();
    while (!m_run) tick();
    tick();
  endtask

  initial begin
    // Run A: request pending through start-up, random waits (R1 R2 R3 R4 R5 R6 R7 R8)
    nx_ctx = make_ctx(32'h1000_0000);
    nx_irq_req = 1'b1; nx_irq_num = 8'd7;
    do_reset(32'h2000_0400, 1);
    while (!m_handler) tick();
    nx_ctx = make_ctx(32'h5555_0000);
    tick(); tick();
    chk(sp_out, 32'h2000_0400 - 32'd32, "R7", "sp after frame");
    chk(pc_out, (32'h0800_0000 ^ 32'h2000_0000 | 32'h0000_005C | 32'h1) & ~32'h1 & 32'hFFFF_FFFF,
        "R8", "handler pc slot 23");
    // request in handler mode is ignored (R9)
    nx_irq_num = 8'd2;
    repeat (20) tick();
    chk(32'(mem_valid), 0, "R9", "no access in handler mode");
    chk(32'(mode_handler), 1, "R9", "mode stays handler");
    nx_irq_req = 1'b0;

    // Run B: zero waits, out-of-range number then top slot (R5)
    do_reset(32'h3000_1002, 0);
    wait_until_run();
    chk(sp_out, 32'h3000_1000, "R1", "sp low bits cleared");
    chk(pc_out, 32'h0001_1002, "R2", "reset pc bit0 cleared");
    nx_irq_req = 1'b1; nx_irq_num = 8'd240; nx_ctx = make_ctx(32'h0BAD_0000);
    repeat (6) tick();
    chk(32'(mem_valid), 0, "R5", "number 240 ignored, no access");
    chk(32'(core_run), 1, "R5", "number 240 ignored, core runs");
    chk(sp_out, 32'h3000_1000, "R5", "number 240 ignored, sp kept");
    nx_irq_num = 8'd239; nx_ctx = make_ctx(32'hC0DE_0000);
    tick();
    nx_irq_req = 1'b0;
    while (!m_handler) tick();
    tick();
    chk(32'(mode_handler), 1, "R8", "handler mode after slot 255");

    // Run C: one-cycle pulse, context keeps changing afterwards (R6 snapshot)
    do_reset(32'h4444_0801, 1);
    wait_until_run();
    nx_irq_req = 1'b1; nx_irq_num = 8'd0; nx_ctx = make_ctx(32'h7000_0000);
    tick();
    nx_irq_req = 1'b0;
    for (int i = 0; i < 12; i++) begin
      nx_ctx = make_ctx(32'h9000_0000 + 32'(i));
      tick();
    end
    while (!m_handler) tick();
    tick();
    chk(sp_out, 32'h4444_0800 - 32'd32, "R7", "sp after slot 16 entry");
    chk(32'(core_run), 1, "R8", "core runs in handler");

    finish_run();
  end
endmodule